// File: doc/BRIEF.md
# Blocking Write-Back Data Cache

This block sits between a processor load/store port and a slow block-wide memory. It is a direct-mapped data cache of 1024 lines, each holding four 32-bit words (16 KB of data). Stores that hit change only the cached copy and mark the line as modified. A miss brings in the whole 16-byte block, and this applies to stores as well as loads. When the line being replaced holds modified data, that data is sent to memory first, and only then is the new block requested.

The processor raises a request and holds it stable until the cache answers with a one-cycle ready pulse. A hit finishes in the cycle after the request is seen. A miss keeps the processor waiting while a four-state controller (idle, tag check, write-back, fill) runs the memory transfers. The memory side uses the same valid/ready style but carries 128-bit blocks. It may take any number of cycles to answer, and the controller holds its request steady until memory ready is seen.

Top module: `wb_cache_top`

## Requirements
- R1: A byte address is split into tag bits [31:14], line index bits [13:4] and word select bits [3:2]; bits [1:0] are ignored. Two addresses with the same index but different tags compete for one line.
- R2: After reset every line is invalid, cpuReady and memValid are low, and the first access to any line is a miss.
- R3: A read hit asserts cpuReady, for exactly one cycle, in the cycle after the request is first sampled. It returns the selected word and causes no memory transfer.
- R4: A write hit updates the selected word only in the cache, starts no memory transfer, and marks the line modified.
- R5: A write miss fetches the block, then merges the written word at word select [3:2] into it. The other three words keep their memory values.
- R6: When a modified line is replaced, one memory write of the old 128-bit line, at the old tag and index, comes before the fetch of the new block. A later read of the old address returns the modified data.
- R7: Replacing an unmodified or invalid line issues only the block fetch, with no write-back.
- R8: The cache is blocking. cpuReady stays low while a memory transfer is outstanding, and a miss waits for memReady however many cycles it takes.
- R9: memAddr is block aligned (bits [3:0] zero). memValid, memWrite and memAddr hold steady until memReady is seen.
- R10: After a fill the access completes as a hit. A read returns the most recently written value of the addressed word, or the memory's value if the word was never written. Memory words map to memWdata/memRdata with word 0 in bits [31:0] and word 3 in bits [127:96].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuValid | input | 1 | Processor request present, held until cpuReady |
| cpuWrite | input | 1 | 1 = store, 0 = load |
| cpuAddr | input | 32 | Byte address |
| cpuWdata | input | 32 | Store data |
| cpuRdata | output | 32 | Load data, valid with cpuReady |
| cpuReady | output | 1 | Request completes this cycle |
| memValid | output | 1 | Memory request present |
| memWrite | output | 1 | 1 = block write-back, 0 = block fetch |
| memAddr | output | 32 | Block-aligned memory address |
| memWdata | output | 128 | Line being written back |
| memRdata | input | 128 | Fetched block, valid with memReady |
| memReady | input | 1 | Memory transfer completes this cycle |

## Verification
The bench builds a conflict between two tags on one index after a store hit, and checks that the write-back comes first and carries the merged word. A design that fetches first or drops the dirty mark would return stale data on the later re-read, or show a missing or misordered write transfer. It also performs a write miss followed by reads of the stored word and a neighbouring word, which catches a fill that overwrites the merged word or a merge into the wrong slot. The bench compares miss latency at two memory delays to expose a controller that does not wait for memReady, and it checks the index at its top value to catch mis-sliced address fields.

// File: rtl/wb_cache_pkg.sv
package wb_cache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CMP   = 2'd1,
    ST_WBACK = 2'd2,
    ST_FILL  = 2'd3
  } ctrlState_t;

  typedef struct packed {
    logic wordWr;      // merge processor word into the current line
    logic fillLine;    // load fetched block, mark clean and valid
    logic victimAddr;  // drive memAddr from the stored tag
  } dpStrobe_t;

endpackage

// File: rtl/wb_cache_ctrl.sv
module wb_cache_ctrl
  import wb_cache_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cpuValid,
  input  logic      cpuWrite,
  input  logic      hit,
  input  logic      victimDirty,
  input  logic      memReady,
  output logic      cpuReady,
  output logic      memValid,
  output logic      memWrite,
  output dpStrobe_t strb
);

  ctrlState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    cpuReady  = 1'b0;
    memValid  = 1'b0;
    memWrite  = 1'b0;
    unique case (state)
      ST_IDLE: if (cpuValid) nextState = ST_CMP;
      ST_CMP: begin
        if (hit) begin
          cpuReady    = 1'b1;
          strb.wordWr = cpuWrite;
          nextState   = ST_IDLE;
        end else if (victimDirty) begin
          nextState = ST_WBACK;
        end else begin
          nextState = ST_FILL;
        end
      end
      ST_WBACK: begin
        memValid        = 1'b1;
        memWrite        = 1'b1;
        strb.victimAddr = 1'b1;
        if (memReady) nextState = ST_FILL;
      end
      ST_FILL: begin
        memValid = 1'b1;
        if (memReady) begin
          strb.fillLine = 1'b1;
          nextState     = ST_CMP;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/wb_cache_dpath.sv
module wb_cache_dpath
  import wb_cache_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int WORDS   = 4,
  parameter int INDEX_W = 10
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_W-1:0]        cpuAddr,
  input  logic [DATA_W-1:0]        cpuWdata,
  input  dpStrobe_t                strb,
  input  logic [DATA_W*WORDS-1:0]  memRdata,
  output logic [DATA_W-1:0]        cpuRdata,
  output logic                     hit,
  output logic                     victimDirty,
  output logic [ADDR_W-1:0]        memAddr,
  output logic [DATA_W*WORDS-1:0]  memWdata
);

  localparam int BYTE_OFF_W = $clog2(DATA_W / 8);
  localparam int WSEL_W     = $clog2(WORDS);
  localparam int OFF_W      = BYTE_OFF_W + WSEL_W;
  localparam int TAG_W      = ADDR_W - INDEX_W - OFF_W;
  localparam int LINE_W     = DATA_W * WORDS;
  localparam int LINES      = 1 << INDEX_W;

  logic [TAG_W-1:0]  tagArr  [LINES];
  logic [LINE_W-1:0] dataArr [LINES];
  logic [LINES-1:0]  validArr;
  logic [LINES-1:0]  dirtyArr;

  logic [TAG_W-1:0]   reqTag;
  logic [INDEX_W-1:0] reqIdx;
  logic [WSEL_W-1:0]  reqWord;
  logic [LINE_W-1:0]  curLine;
  logic               unusedByteBits;

  assign reqTag         = cpuAddr[ADDR_W-1 -: TAG_W];
  assign reqIdx         = cpuAddr[OFF_W +: INDEX_W];
  assign reqWord        = cpuAddr[BYTE_OFF_W +: WSEL_W];
  assign unusedByteBits = ^cpuAddr[BYTE_OFF_W-1:0];

  assign curLine     = dataArr[reqIdx];
  assign hit         = validArr[reqIdx] && (tagArr[reqIdx] == reqTag);
  assign victimDirty = validArr[reqIdx] && dirtyArr[reqIdx];
  assign cpuRdata    = curLine[reqWord*DATA_W +: DATA_W];
  assign memWdata    = curLine;
  assign memAddr     = strb.victimAddr ? {tagArr[reqIdx], reqIdx, {OFF_W{1'b0}}}
                                       : {reqTag, reqIdx, {OFF_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validArr <= '0;
      dirtyArr <= '0;
    end else if (strb.fillLine) begin
      validArr[reqIdx] <= 1'b1;
      dirtyArr[reqIdx] <= 1'b0;
    end else if (strb.wordWr) begin
      dirtyArr[reqIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.fillLine) begin
      tagArr[reqIdx]  <= reqTag;
      dataArr[reqIdx] <= memRdata;
    end else if (strb.wordWr) begin
      dataArr[reqIdx][reqWord*DATA_W +: DATA_W] <= cpuWdata;
    end
  end

endmodule

// File: rtl/wb_cache_top.sv
module wb_cache_top
  import wb_cache_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int WORDS   = 4,
  parameter int INDEX_W = 10
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cpuValid,
  input  logic                    cpuWrite,
  input  logic [ADDR_W-1:0]       cpuAddr,
  input  logic [DATA_W-1:0]       cpuWdata,
  output logic [DATA_W-1:0]       cpuRdata,
  output logic                    cpuReady,
  output logic                    memValid,
  output logic                    memWrite,
  output logic [ADDR_W-1:0]       memAddr,
  output logic [DATA_W*WORDS-1:0] memWdata,
  input  logic [DATA_W*WORDS-1:0] memRdata,
  input  logic                    memReady
);

  dpStrobe_t strb;
  logic      hit;
  logic      victimDirty;

  wb_cache_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .cpuValid(cpuValid), .cpuWrite(cpuWrite),
    .hit(hit), .victimDirty(victimDirty), .memReady(memReady),
    .cpuReady(cpuReady), .memValid(memValid), .memWrite(memWrite),
    .strb(strb)
  );

  wb_cache_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .INDEX_W(INDEX_W)
  ) i_dpath (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .strb(strb), .memRdata(memRdata), .cpuRdata(cpuRdata), .hit(hit),
    .victimDirty(victimDirty), .memAddr(memAddr), .memWdata(memWdata)
  );

endmodule

// File: rtl/wb_cache_chk.sv
module wb_cache_chk #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuValid,
  input logic              cpuReady,
  input logic              memValid,
  input logic              memWrite,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memReady
);

  // R8: processor never released while memory is busy
  a_r8_blocking: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> !cpuReady);

  // R9: block-aligned memory address
  a_r9_aligned: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> (memAddr[OFF_W-1:0] == '0));

  // R9: request held until accepted
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (memValid && $stable(memAddr) && $stable(memWrite)));

  // R6: a finished write-back is followed straight by a fetch
  a_r6_wb_then_fetch: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memWrite && memReady) |=> (memValid && !memWrite));

  // R3: ready is a single-cycle pulse for a live request
  a_r3_single_ready: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |=> !cpuReady);

  a_r3_ready_needs_req: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |-> cpuValid);

endmodule

bind wb_cache_top wb_cache_chk #(.ADDR_W(ADDR_W), .OFF_W($clog2(DATA_W / 8) + $clog2(WORDS))) i_chk (
  .clk(clk), .rstN(rstN), .cpuValid(cpuValid), .cpuReady(cpuReady),
  .memValid(memValid), .memWrite(memWrite), .memAddr(memAddr), .memReady(memReady)
);

// File: tb/test_wb_cache_top.sv
module test_wb_cache_top;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         cpuValid = 1'b0;
  logic         cpuWrite = 1'b0;
  logic [31:0]  cpuAddr = '0;
  logic [31:0]  cpuWdata = '0;
  logic [31:0]  cpuRdata;
  logic         cpuReady;
  logic         memValid;
  logic         memWrite;
  logic [31:0]  memAddr;
  logic [127:0] memWdata;
  logic [127:0] memRdata = '0;
  logic         memReady = 1'b0;

  int checks = 0;
  int errors = 0;
  int memLat = 2;
  int latCnt = 0;
  int lastLat = 0;

  logic [127:0] blocks [int];
  logic [31:0]  shadow [int];
  logic [31:0]  expQ   [$];
  logic [31:0]  addrQ  [$];
  logic         opWr   [$];
  logic [31:0]  opAddr [$];
  logic [127:0] opData [$];

  always #4 clk = ~clk;  // 125 MHz

  wb_cache_top i_wb_cache_top (
    .clk(clk), .rstN(rstN), .cpuValid(cpuValid), .cpuWrite(cpuWrite),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuRdata(cpuRdata),
    .cpuReady(cpuReady), .memValid(memValid), .memWrite(memWrite),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .memReady(memReady)
  );

  function automatic logic [31:0] initWord(input logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'hC0DE_0000;
  endfunction

  function automatic logic [127:0] readBlock(input logic [31:0] a);
    logic [127:0] b;
    if (blocks.exists(int'(a >> 4))) return blocks[int'(a >> 4)];
    for (int w = 0; w < 4; w++) b[w*32 +: 32] = initWord({a[31:4], 4'b0} + 32'(w*4));
    return b;
  endfunction

  function automatic logic [31:0] expWord(input logic [31:0] a);
    if (shadow.exists(int'(a >> 2))) return shadow[int'(a >> 2)];
    return initWord(a);
  endfunction

  // Memory model with programmable delay
  always @(posedge clk) begin
    if (!rstN) begin
      memReady <= 1'b0;
      latCnt   <= 0;
    end else if (memReady) begin
      memReady <= 1'b0;
      latCnt   <= 0;
    end else if (memValid) begin
      if (latCnt >= memLat) begin
        memReady <= 1'b1;
        opWr.push_back(memWrite);
        opAddr.push_back(memAddr);
        opData.push_back(memWdata);
        if (memWrite) blocks[int'(memAddr >> 4)] = memWdata;
        else          memRdata <= readBlock(memAddr);
      end else begin
        latCnt <= latCnt + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: compares each completed read (R10)
  always @(negedge clk) begin
    if (rstN && cpuValid && cpuReady && !cpuWrite) begin
      logic [31:0] e;
      logic [31:0] a;
      e = expQ.pop_front();
      a = addrQ.pop_front();
      check(cpuRdata == e, $sformatf("R10 read @%0h", a), cpuRdata, e);
    end
  end

  task automatic access(input bit wr, input logic [31:0] a, input logic [31:0] d);
    int n = 0;
    if (!wr) begin
      expQ.push_back(expWord(a));
      addrQ.push_back(a);
    end else begin
      shadow[int'(a >> 2)] = d;
    end
    cpuValid = 1'b1; cpuWrite = wr; cpuAddr = a; cpuWdata = d;
    do begin
      @(posedge clk); @(negedge clk); n++;
      if (memValid && cpuReady) check(0, "R8 ready during memory op", 1, 0);
    end while (!cpuReady);
    lastLat = n;
    @(posedge clk); @(negedge clk);
    cpuValid = 1'b0;
  endtask

  task automatic clearOps();
    opWr.delete(); opAddr.delete(); opData.delete();
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    check(0, "watchdog", cyc, 100000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int latShort;
    repeat (3) @(negedge clk);
    // R2: reset state
    check(cpuReady == 0 && memValid == 0, "R2 reset outputs", {cpuReady, memValid}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 R7: cold miss fetches only
    clearOps();
    access(0, 32'h0000_0010, 0);
    check(opWr.size() == 1 && opWr[0] == 0, "R2 cold miss single fetch", opWr.size(), 1);
    check(opAddr[0] == 32'h10, "R9 fetch address", opAddr[0], 32'h10);

    // R3: hit latency and no traffic
    clearOps();
    access(0, 32'h0000_0014, 0);
    check(lastLat == 1, "R3 hit latency", lastLat, 1);
    check(opWr.size() == 0, "R3 hit no memory op", opWr.size(), 0);

    // R4: write hit stays in cache; R1 byte bits ignored
    clearOps();
    access(1, 32'h0000_0018, 32'hDEAD_0018);
    check(opWr.size() == 0, "R4 write hit no memory op", opWr.size(), 0);
    access(0, 32'h0000_001B, 0);
    check(opWr.size() == 0, "R4 read back hit", opWr.size(), 0);

    // R6 R1: conflicting tag evicts dirty line first
    clearOps();
    access(0, 32'h0000_4010, 0);
    check(opWr.size() == 2, "R6 two memory ops", opWr.size(), 2);
    if (opWr.size() == 2) begin
      check(opWr[0] == 1 && opAddr[0] == 32'h10, "R6 write-back first", opAddr[0], 32'h10);
      check(opData[0][95:64] == 32'hDEAD_0018, "R6 write-back data", opData[0][95:64], 32'hDEAD_0018);
      check(opWr[1] == 0 && opAddr[1] == 32'h4010, "R6 fetch second", opAddr[1], 32'h4010);
    end

    // R7: clean victim, R6 modified data came back from memory
    clearOps();
    access(0, 32'h0000_0018, 0);
    check(opWr.size() == 1 && opWr[0] == 0, "R7 clean victim no write-back", opWr.size(), 1);

    // R5: write miss allocate and merge
    clearOps();
    access(1, 32'h0000_8024, 32'h1234_5678);
    check(opWr.size() == 1 && opWr[0] == 0, "R5 write miss fetch", opWr.size(), 1);
    access(0, 32'h0000_8024, 0);
    access(0, 32'h0000_8020, 0);
    access(0, 32'h0000_802C, 0);
    check(opWr.size() == 1, "R5 reads hit after allocate", opWr.size(), 1);

    // R1: top index value
    clearOps();
    access(1, 32'h0000_3FFC, 32'hFACE_3FFC);
    access(0, 32'h0000_7FF0, 0);
    check(opWr.size() == 3 && opWr[1] == 1 && opAddr[1] == 32'h3FF0,
          "R1 top index write-back", opAddr.size() > 1 ? opAddr[1] : 0, 32'h3FF0);
    if (opData.size() > 1)
      check(opData[1][127:96] == 32'hFACE_3FFC, "R1 word 3 position", opData[1][127:96], 32'hFACE_3FFC);
    access(0, 32'h0000_3FFC, 0);

    // R8: latency follows memory delay
    memLat = 0;
    access(0, 32'h0000_0100, 0);
    latShort = lastLat;
    memLat = 9;
    access(0, 32'h0000_0200, 0);
    check(lastLat - latShort == 9, "R8 waits for memReady", lastLat - latShort, 9);

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R10 all reads completed", expQ.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule